// File: doc/BRIEF.md
# Compare Output Pin Unit

This block keeps the one-bit waveform state of a single timer compare channel and decides what a general-purpose I/O pin drives. A compare-match pulse from the timer, or a software force strobe, updates the state bit. A two-bit action field chooses whether that update toggles, clears or sets the bit, or leaves it alone.

The same action field also takes the pin over. While the field is nonzero, the pin's output value comes from the state bit instead of the port data latch. The pin's drive enable always follows the port's direction bit. A timer uses this block to present a compare waveform on a shared pin. The counter, the compare register and any interrupt logic sit outside it.

Top module: `cmp_pin_unit`

## Requirements
- R1: After reset the state bit is 0. With a nonzero action field and the direction bit at 1, pinOut reads 0 until the first update.
- R2: When cmpMode is nonzero, pinOut equals the state bit. When cmpMode is 2'b00, pinOut equals portData.
- R3: pinOe always equals portDir, whatever cmpMode holds. A direction of 0 keeps the pin undriven even while cmpMode is nonzero.
- R4: On a clock edge where cmpMatch is 1 and cmpMode is 2'b01, the state bit inverts.
- R5: On an update edge, cmpMode 2'b10 makes the state bit 0 and cmpMode 2'b11 makes it 1.
- R6: With cmpMode 2'b00, an update edge leaves the state bit unchanged.
- R7: A forceStrobe with no compare match updates the state bit exactly as a match would under the same cmpMode.
- R8: A compare match and a force strobe on the same edge update the state bit once, so toggle mode inverts it a single time.
- R9: A change of cmpMode changes the pin source in the same cycle, with no shadow copy. A cycle without a match or strobe leaves the state bit as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpMatch | input | 1 | One-cycle compare-match pulse from the timer |
| forceStrobe | input | 1 | Force-compare strobe |
| cmpMode | input | 2 | Action field: 00 none, 01 toggle, 10 clear, 11 set |
| portData | input | 1 | Port data latch bit |
| portDir | input | 1 | Direction bit, 1 = output |
| pinOut | output | 1 | Value driven to the pin |
| pinOe | output | 1 | Pin output enable |

## Verification
The bench builds the block with the package defaults: a two-bit action field and a one-bit state. This lets random stimulus reach all four action codes in every combination of match, strobe, data and direction within a few thousand cycles. Directed cases set up a toggle with match and strobe together, a force strobe with no match, an action-field change in the middle of a run, and an input direction while the pin is overridden.

// File: rtl/cmp_pin_pkg.sv
package cmp_pin_pkg;
  localparam int ModeW = 2;

  typedef enum logic [ModeW-1:0] {
    ActNone   = 2'b00,
    ActToggle = 2'b01,
    ActClear  = 2'b10,
    ActSet    = 2'b11
  } act_e;

  typedef struct packed {
    logic apply;     // update the state bit at this edge
    act_e action;    // how to update it
    logic override;  // pin value comes from state bit
  } ctl_s;
endpackage

// File: rtl/cmp_pin_ctl.sv
module cmp_pin_ctl
  import cmp_pin_pkg::*;
#(
  parameter int MODE_W = ModeW
) (
  input  logic              cmpMatch,
  input  logic              forceStrobe,
  input  logic [MODE_W-1:0] cmpMode,
  output ctl_s              ctl
);
  logic anyEvent;

  // match and force merge into one event: a single update per edge
  assign anyEvent = cmpMatch | forceStrobe;

  always_comb begin
    ctl.action   = act_e'(cmpMode);
    ctl.apply    = anyEvent && (cmpMode != '0);
    ctl.override = |cmpMode;
  end
endmodule

// File: rtl/cmp_pin_dp.sv
module cmp_pin_dp
  import cmp_pin_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ctl_s ctl,
  input  logic portData,
  input  logic portDir,
  output logic stateBit,
  output logic pinOut,
  output logic pinOe
);
  logic nextState;

  always_comb begin
    nextState = stateBit;
    if (ctl.apply) begin
      unique case (ctl.action)
        ActToggle: nextState = ~stateBit;
        ActClear:  nextState = 1'b0;
        ActSet:    nextState = 1'b1;
        default:   nextState = stateBit;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateBit <= 1'b0;
    else       stateBit <= nextState;
  end

  assign pinOut = ctl.override ? stateBit : portData;
  assign pinOe  = portDir;
endmodule

// File: rtl/cmp_pin_unit.sv
module cmp_pin_unit
  import cmp_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpMatch,
  input  logic             forceStrobe,
  input  logic [ModeW-1:0] cmpMode,
  input  logic             portData,
  input  logic             portDir,
  output logic             pinOut,
  output logic             pinOe
);
  ctl_s ctl;
  logic stateBit;

  cmp_pin_ctl #(.MODE_W(ModeW)) u_ctl (
    .cmpMatch(cmpMatch), .forceStrobe(forceStrobe), .cmpMode(cmpMode), .ctl(ctl)
  );

  cmp_pin_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .portData(portData), .portDir(portDir),
    .stateBit(stateBit), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/cmp_pin_unit_chk.sv
module cmp_pin_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmpMatch,
  input logic       forceStrobe,
  input logic [1:0] cmpMode,
  input logic       portData,
  input logic       portDir,
  input logic       stateBit,
  input logic       pinOut,
  input logic       pinOe
);
  logic ev;
  assign ev = cmpMatch | forceStrobe;

  p_reset_r1: assert property (@(posedge clk) !rstN |=> !stateBit);
  p_src_state_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmpMode != 2'b00) |-> (pinOut == stateBit));
  p_src_port_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmpMode == 2'b00) |-> (pinOut == portData));
  p_oe_dir_r3: assert property (@(posedge clk) disable iff (!rstN) pinOe == portDir);
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ev && cmpMode == 2'b01) |=> (stateBit != $past(stateBit)));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ev && cmpMode == 2'b10) |=> !stateBit);
  p_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ev && cmpMode == 2'b11) |=> stateBit);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ev || cmpMode == 2'b00) |=> $stable(stateBit));
endmodule

bind cmp_pin_unit cmp_pin_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .cmpMatch(cmpMatch), .forceStrobe(forceStrobe),
  .cmpMode(cmpMode), .portData(portData), .portDir(portDir),
  .stateBit(stateBit), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/cmp_pin_unit_bench.sv
`timescale 1ns/1ps
module cmp_pin_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpMatch = 1'b0, forceStrobe = 1'b0, portData = 1'b0, portDir = 1'b0;
  logic [1:0] cmpMode = 2'b00;
  logic pinOut, pinOe;
  logic expState;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_pin_unit u_cmp_pin_unit (
    .clk(clk), .rstN(rstN), .cmpMatch(cmpMatch), .forceStrobe(forceStrobe),
    .cmpMode(cmpMode), .portData(portData), .portDir(portDir),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic logic nextOf(logic cur, logic [1:0] m, logic ev);
    if (!ev) return cur;
    case (m)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  function automatic logic expPin(logic st, logic [1:0] m, logic d);
    return (m != 2'b00) ? st : d;
  endfunction

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at negedge, check outputs, then let posedge apply the event
  task automatic cyc(string req, logic m0, logic f0, logic [1:0] md, logic d, logic dir);
    @(negedge clk);
    cmpMatch = m0; forceStrobe = f0; cmpMode = md; portData = d; portDir = dir;
    #1;
    check({req, " pinOut"}, pinOut, expPin(expState, md, d));
    check("R3 pinOe", pinOe, dir);
    expState = nextOf(expState, md, m0 | f0);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    expState = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset value seen through override
    cyc("R1", 0, 0, 2'b11, 1, 1);
    cyc("R1", 0, 0, 2'b11, 1, 1);
    // R4 toggle by match
    cyc("R4", 1, 0, 2'b01, 0, 1);
    cyc("R4", 0, 0, 2'b01, 0, 1);
    check("R4 toggled", pinOut, 1'b1);
    // R8 match and force together: single toggle
    cyc("R8", 1, 1, 2'b01, 1, 1);
    cyc("R8", 0, 0, 2'b01, 1, 1);
    check("R8 single toggle", pinOut, 1'b0);
    // R7 force alone sets
    cyc("R7", 0, 1, 2'b11, 0, 1);
    cyc("R7", 0, 0, 2'b11, 0, 1);
    check("R7 force set", pinOut, 1'b1);
    // R5 clear
    cyc("R5", 1, 0, 2'b10, 1, 1);
    cyc("R5", 0, 0, 2'b10, 1, 1);
    check("R5 clear", pinOut, 1'b0);
    // R6 mode 00 event: no change, pin shows port data
    cyc("R6", 0, 1, 2'b11, 0, 1);
    cyc("R6", 1, 1, 2'b00, 0, 1);
    cyc("R6", 0, 0, 2'b11, 0, 1);
    check("R6 held", pinOut, 1'b1);
    // R9 immediate mode switch to port source, state kept
    cyc("R9", 0, 0, 2'b00, 0, 1);
    check("R9 port source", pinOut, 1'b0);
    cyc("R9", 0, 0, 2'b10, 0, 1);
    check("R9 state source", pinOut, 1'b1);
    // R3 input direction with override
    cyc("R3", 0, 0, 2'b01, 1, 0);
    check("R3 oe low", pinOe, 1'b0);
    // random mix (R2 R4 R5 R6 R7)
    for (int i = 0; i < 3000; i++) begin
      cyc("R2", ($urandom % 4) == 0, ($urandom % 6) == 0, 2'($urandom),
          1'($urandom), 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule